// File: doc/BRIEF.md
# Peripheral Idle and Reset Controller

This block handles the power management side of a small memory-mapped peripheral. A single configuration register selects one of four idle policies, enables wake-up reporting, enables automatic gating of the interface clock, and carries a self-clearing soft-reset trigger. A read-only status register reports whether the internal reset sequence has finished.

A system power manager raises an idle request. The block answers with an acknowledge according to the selected policy. Force-idle always agrees, no-idle never agrees, and the two smart policies agree only while the peripheral is quiet. In the smart policy with wake-up, a qualifying event that arrives while idle is acknowledged raises a wake-up request. That request is held until the manager withdraws its idle request. The block also emits a clock-gate enable that an external gating cell may use when automatic gating is selected and the bus is quiet.

Top module: `pwr_idle_ctl`

## Requirements
- R1: After the reset input is released, the configuration register reads 0, the status register reads 1 (reset done in bit 0), and idle_ack and wakeup are 0.
- R2: A write to the configuration offset 0x010 stores auto-gate in bit 0, wake enable in bit 2 and idle mode in bits 4:3. A read returns them in the same positions, with bit 1 and bits 31:5 always reading 0.
- R3: A write with bit 1 set starts an internal reset. In the write itself, all configuration fields become 0. Reset-done (bit 0 of the status offset 0x114) reads 0 for exactly 4 cycles after the write edge and then returns to 1. Configuration writes made while the reset runs are ignored.
- R4: In idle mode 0 (force), idle_ack rises one cycle after idle_req, whatever the bus and interrupt state.
- R5: In idle mode 1 (no-idle), idle_ack stays 0 while idle_req is held.
- R6: In idle modes 2 and 3 (smart), idle_ack is 1 one cycle after a cycle in which idle_req is high, bus_pending and req_valid are low, and all irq_status bits are 0. It is 0 one cycle after any of these conditions fails.
- R7: idle_ack is 0 in the cycle after the cycle in which idle_req is low.
- R8: In mode 3 with wake enable set, wake_evt high while idle_ack is high raises wakeup on the next cycle. wakeup then stays high, even after wake_evt falls, until the cycle after idle_req falls.
- R9: wakeup stays 0 when wake enable is clear, or when the mode is not 3, even if wake_evt is high while idle is acknowledged.
- R10: clk_gate_en is 1 exactly when auto-gate is set and neither bus_pending nor req_valid is high.
- R11: Reads of any offset other than 0x010 and 0x114 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus transfer valid this cycle |
| req_write | input | 1 | Transfer is a write |
| req_addr | input | 12 | Byte offset of the transfer or read |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr (combinational) |
| bus_pending | input | 1 | Another bus transfer is outstanding |
| irq_status | input | 4 | Interrupt status bits of the peripheral |
| wake_evt | input | 1 | An enabled input event is pending |
| idle_req | input | 1 | Idle request from the power manager |
| idle_ack | output | 1 | Idle acknowledge |
| wakeup | output | 1 | Wake-up request |
| clk_gate_en | output | 1 | Interface clock may be gated |

## Verification
A wrong stored idle mode shows on idle_ack one cycle after the idle request, because each policy gives a different answer under the same bus and interrupt conditions. A stuck or miscounted reset counter shows on the status read. Reset-done either falls for a number of cycles other than four, or fails to return. Leftover configuration bits after a soft reset show on the next configuration read. A lost wake-up hold state shows as wakeup falling while idle_req is still high, one cycle after the event ends.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

  typedef enum logic [1:0] {
    IDLE_FORCE   = 2'd0,
    IDLE_NEVER   = 2'd1,
    IDLE_SMART   = 2'd2,
    IDLE_SMART_W = 2'd3
  } idle_mode_e;

  typedef struct packed {
    idle_mode_e mode;
    logic       wake_en;
    logic       auto_gate;
  } cfg_t;

  // Policy decision: may an idle request be granted this cycle
  function automatic logic ack_allowed(idle_mode_e m, logic busy, logic irq_any);
    case (m)
      IDLE_FORCE:   ack_allowed = 1'b1;
      IDLE_NEVER:   ack_allowed = 1'b0;
      default:      ack_allowed = !busy && !irq_any;
    endcase
  endfunction

  // Register image of the configuration fields
  function automatic logic [31:0] pack_cfg(cfg_t c);
    pack_cfg = {27'd0, c.mode, c.wake_en, 1'b0, c.auto_gate};
  endfunction

  function automatic cfg_t unpack_cfg(logic [31:0] w);
    cfg_t c;
    c.mode      = idle_mode_e'(w[4:3]);
    c.wake_en   = w[2];
    c.auto_gate = w[0];
    unpack_cfg  = c;
  endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_idle_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_ADDR  = 'h010,
  parameter int STAT_ADDR = 'h114,
  parameter int RST_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output cfg_t              cfg,
  output logic              rst_done,
  output logic              soft_rst_fire,
  output logic [31:0]       rd_data
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] rst_cnt;
  logic             cfg_hit;

  assign cfg_hit       = wr_en && (addr == ADDR_W'(CFG_ADDR));
  assign rst_done      = (rst_cnt == '0);
  assign soft_rst_fire = cfg_hit && rst_done && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      rst_cnt <= '0;
    end else if (!rst_done) begin
      rst_cnt <= rst_cnt - 1'b1;
    end else if (soft_rst_fire) begin
      cfg     <= '0;
      rst_cnt <= CNT_W'(RST_CYC);
    end else if (cfg_hit) begin
      cfg     <= unpack_cfg(wdata);
    end
  end

  always_comb begin
    if (addr == ADDR_W'(CFG_ADDR))       rd_data = pack_cfg(cfg);
    else if (addr == ADDR_W'(STAT_ADDR)) rd_data = {31'd0, rst_done};
    else                                 rd_data = '0;
  end

endmodule

// File: rtl/pwr_idle_hs.sv
module pwr_idle_hs
  import pwr_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic idle_req,
  input  logic busy,
  input  logic irq_any,
  input  logic wake_evt,
  output logic idle_ack,
  output logic wakeup,
  output logic wake_fire
);
  logic grant;

  assign grant     = idle_req && ack_allowed(cfg.mode, busy, irq_any);
  assign wake_fire = idle_ack && idle_req && (cfg.mode == IDLE_SMART_W)
                     && cfg.wake_en && wake_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ack <= 1'b0;
      wakeup   <= 1'b0;
    end else begin
      idle_ack <= grant;
      wakeup   <= idle_req && (wakeup || wake_fire);
    end
  end

endmodule

// File: rtl/pwr_idle_ctl.sv
module pwr_idle_ctl
  import pwr_idle_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int IRQ_W     = 4,
  parameter int CFG_ADDR  = 'h010,
  parameter int STAT_ADDR = 'h114,
  parameter int RST_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic              bus_pending,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic              wake_evt,
  input  logic              idle_req,
  output logic              idle_ack,
  output logic              wakeup,
  output logic              clk_gate_en
);
  cfg_t cfg;
  logic rst_done;
  logic soft_rst_fire;
  logic wake_fire;
  logic bus_busy;
  logic irq_any;

  assign bus_busy    = bus_pending || req_valid;
  assign irq_any     = |irq_status;
  assign clk_gate_en = cfg.auto_gate && !bus_busy;

  pwr_cfg_regs #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR), .RST_CYC(RST_CYC)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(req_valid && req_write), .addr(req_addr),
    .wdata(req_wdata), .cfg(cfg), .rst_done(rst_done),
    .soft_rst_fire(soft_rst_fire), .rd_data(rd_data)
  );

  pwr_idle_hs i_hs (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .idle_req(idle_req), .busy(bus_busy),
    .irq_any(irq_any), .wake_evt(wake_evt), .idle_ack(idle_ack),
    .wakeup(wakeup), .wake_fire(wake_fire)
  );

endmodule

// File: rtl/pwr_idle_ctl_chk.sv
module pwr_idle_ctl_chk
  import pwr_idle_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] req_addr,
  input logic [31:0] rd_data,
  input logic        bus_pending,
  input logic        idle_req,
  input logic        idle_ack,
  input logic        wakeup,
  input cfg_t        cfg,
  input logic        rst_done,
  input logic        soft_rst_fire
);
  // R2: reserved and self-clearing bits of the configuration image read zero
  p_cfg_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == 12'h010) |-> (rd_data[31:5] == '0 && !rd_data[1]));

  // R3: configuration is all zero while the internal reset runs
  p_reset_clears_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_done |-> (cfg == '0));

  // R3: a soft reset trigger makes reset-done fall on the next cycle
  p_reset_done_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_fire |=> !rst_done);

  // R5: no-idle never grants
  p_never_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == IDLE_NEVER) |=> !idle_ack);

  // R6: smart modes refuse while a transfer is pending
  p_smart_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode[1] && bus_pending) |=> !idle_ack);

  // R7: acknowledge follows withdrawal within one cycle
  p_ack_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack);

  // R8: wake-up is released once the request is gone
  p_wake_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !wakeup);

  // R8: wake-up only rises while idle is acknowledged
  p_wake_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ack && !wakeup) |=> !wakeup);

endmodule

bind pwr_idle_ctl pwr_idle_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .rd_data(rd_data),
  .bus_pending(bus_pending), .idle_req(idle_req), .idle_ack(idle_ack),
  .wakeup(wakeup), .cfg(cfg), .rst_done(rst_done), .soft_rst_fire(soft_rst_fire)
);

// File: tb/test_pwr_idle_ctl.sv
`timescale 1ns/1ps
module test_pwr_idle_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        bus_pending = 1'b0;
  logic [3:0]  irq_status = '0;
  logic        wake_evt = 1'b0, idle_req = 1'b0;
  logic        idle_ack, wakeup, clk_gate_en;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [11:0] A_CFG  = 12'h010;
  localparam logic [11:0] A_STAT = 12'h114;

  always #2 clk = ~clk;

  pwr_idle_ctl i_pwr_idle_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .bus_pending(bus_pending), .irq_status(irq_status), .wake_evt(wake_evt),
    .idle_req(idle_req), .idle_ack(idle_ack), .wakeup(wakeup),
    .clk_gate_en(clk_gate_en)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_CFG; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    req_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG, d);  check("R1 cfg after reset", d, 0);
    rd(A_STAT, d); check("R1 status after reset", d, 1);
    check("R1 ack after reset", {31'd0, idle_ack}, 0);
    check("R1 wakeup after reset", {31'd0, wakeup}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(32'hFFFF_FFFD);
    rd(A_CFG, d); check("R2 all fields set", d, 32'h1D);
    wr(32'h0000_0009);
    rd(A_CFG, d); check("R2 mode1 autogate", d, 32'h09);
    wr(32'h0000_0000);
    rd(A_CFG, d); check("R2 cleared", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(32'h1D);
    rd(12'h014, d); check("R11 offset 0x014", d, 0);
    rd(12'h000, d); check("R11 offset 0x000", d, 0);
    rd(12'h110, d); check("R11 offset 0x110", d, 0);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    wr(32'h1D);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_CFG; req_wdata = 32'h1F;
    @(negedge clk);
    req_wdata = 32'h15;
    rd(A_CFG, d);  check("R3 cfg cleared by soft reset", d, 0);
    rd(A_STAT, d); check("R3 done low cycle 1", d, 0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(A_STAT, d); check("R3 done low cycle 2", d, 0);
    @(negedge clk);
    rd(A_STAT, d); check("R3 done low cycle 3", d, 0);
    @(negedge clk);
    rd(A_STAT, d); check("R3 done low cycle 4", d, 0);
    @(negedge clk);
    rd(A_STAT, d); check("R3 done back high", d, 1);
    rd(A_CFG, d);  check("R3 write during reset ignored", d, 0);
  endtask

  task automatic t_force();
    wr(32'h0);
    bus_pending = 1'b1; irq_status = 4'hF; idle_req = 1'b1;
    @(negedge clk);
    check("R4 force ack despite activity", {31'd0, idle_ack}, 1);
    idle_req = 1'b0;
    @(negedge clk);
    check("R7 ack drops after withdraw", {31'd0, idle_ack}, 0);
    bus_pending = 1'b0; irq_status = '0;
  endtask

  task automatic t_noidle();
    wr(32'h08);
    idle_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 no-idle never acks", {31'd0, idle_ack}, 0);
    idle_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_smart();
    wr(32'h10);
    bus_pending = 1'b1; idle_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 smart refuses when bus pending", {31'd0, idle_ack}, 0);
    bus_pending = 1'b0;
    @(negedge clk);
    check("R6 smart grants when quiet", {31'd0, idle_ack}, 1);
    irq_status = 4'b0100;
    @(negedge clk);
    check("R6 smart drops on irq", {31'd0, idle_ack}, 0);
    irq_status = '0;
    @(negedge clk);
    check("R6 smart regrants", {31'd0, idle_ack}, 1);
    idle_req = 1'b0;
    @(negedge clk);
    check("R7 smart ack drops", {31'd0, idle_ack}, 0);
  endtask

  task automatic t_wake();
    wr(32'h1C);
    idle_req = 1'b1;
    @(negedge clk);
    check("R6 mode3 grants", {31'd0, idle_ack}, 1);
    wake_evt = 1'b1;
    @(negedge clk);
    check("R8 wakeup rises", {31'd0, wakeup}, 1);
    wake_evt = 1'b0;
    @(negedge clk);
    check("R8 wakeup held after event", {31'd0, wakeup}, 1);
    idle_req = 1'b0;
    @(negedge clk);
    check("R8 wakeup released", {31'd0, wakeup}, 0);
  endtask

  task automatic t_nowake(logic [31:0] c, string tag);
    wr(c);
    idle_req = 1'b1;
    @(negedge clk);
    wake_evt = 1'b1;
    repeat (2) @(negedge clk);
    check(tag, {31'd0, wakeup}, 0);
    wake_evt = 1'b0; idle_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_gate();
    wr(32'h01);
    #0.5;
    check("R10 gate enabled when quiet", {31'd0, clk_gate_en}, 1);
    bus_pending = 1'b1; #0.5;
    check("R10 gate off when bus pending", {31'd0, clk_gate_en}, 0);
    bus_pending = 1'b0; req_valid = 1'b1; req_addr = 12'h000; #0.5;
    check("R10 gate off during transfer", {31'd0, clk_gate_en}, 0);
    req_valid = 1'b0;
    wr(32'h00);
    #0.5;
    check("R10 gate off when auto-gate clear", {31'd0, clk_gate_en}, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_softrst();
    t_force();
    t_noidle();
    t_smart();
    t_wake();
    t_nowake(32'h18, "R9 no wakeup with wake enable clear");
    t_nowake(32'h14, "R9 no wakeup in mode 2");
    t_gate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule